// File: doc/BRIEF.md
# Seven-Segment Digit Decoder with Ripple Blanking

This block converts a 4-bit value into the segment drive for one seven-segment digit. Values 0 to 9 appear as decimal numerals. Values 10 to 15 appear as the letter shapes A, b, C, d, E and F. The lower-case b and d keep those two shapes distinct from 8 and 0. The outputs are active low, so the block suits a common-anode display directly. The decimal point is not driven here; logic outside the block owns that segment.

Several copies can be chained to suppress leading zeros. Tie the ripple-blank input of the most significant digit low. Feed each digit's ripple-blank output into the ripple-blank input of the next lower digit. Tie the ripple-blank input of the units digit high, so that a value of zero still shows a single "0". The result is that a run of leading zeros goes dark, while zeros to the right of the first non-zero digit stay visible.

A separate forced-blank input darkens the digit whatever the data is. It can save power, or it can be driven with a pulse-width waveform to set the apparent brightness. The path is purely combinational, so the digit is dark for exactly the intervals in which forced blank is held.

Top module: `sevenseg_rb_dec`

## Requirements
- R1: For values 0 to 9 with no blanking active, `seg_n` shows the decimal numeral. Bit 0 is segment a and bit 6 is segment g, and a lit segment is driven 0. The active-low codes are 0:40, 1:79, 2:24, 3:30, 4:19, 5:12, 6:02, 7:78, 8:00, 9:10 (hex).
- R2: Values 10 to 15 show A, b, C, d, E, F with the active-low codes 08, 03, 46, 21, 06, 0E (hex). Every one of them differs from the codes for 8 and 0.
- R3: A dark digit drives all seven `seg_n` bits to 1. Every visible glyph lights at least two segments.
- R4: When `rb_in_n` is 0, `blank_n` is 1 and the value is 0, the digit is dark.
- R5: When `rb_in_n` is 0 and the value is non-zero, the normal glyph is shown.
- R6: `rb_out_n` is 0 exactly when the digit is dark because of R4. In every other case it is 1.
- R7: When `blank_n` is 0, the digit is dark and `rb_out_n` is 1, whatever the values of `digit_val` and `rb_in_n`.
- R8: `seg_n` responds to `blank_n` without any clock. The digit is dark exactly while `blank_n` is 0 and shows its glyph again once `blank_n` returns to 1.
- R9: When `rb_in_n` is 1 and the value is 0, the numeral 0 is shown.
- R10: In a chain of four digits, leading zeros go dark and zeros after the first non-zero digit stay visible. For example, 0x0305 shows blank, 3, 0, 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digit_val | input | 4 | Value to display |
| rb_in_n | input | 1 | Ripple-blank in, active low: blank this digit if its value is zero |
| blank_n | input | 1 | Forced blank, active low, with priority over everything else |
| seg_n | output | 7 | Segment drive, active low, bit 0 = a to bit 6 = g |
| rb_out_n | output | 1 | Ripple-blank out, active low, feeds the next lower digit |

## Verification
The bound checker evaluates the port-level rules whenever any input changes:
- forced blank darkens the digit and holds `rb_out_n` high;
- `rb_out_n` goes low only for a zero value with `rb_in_n` low;
- a zero value with `rb_in_n` low is dark;
- any unblanked digit lights at least two segments.

The exact glyph codes, including the distinctness of b and d, can only be confirmed by the bench's full sweep of values against its own glyph table. The same applies to how a chain of four digits treats leading and inner zeros, and to whether a pulsed forced-blank darkens the digit for exactly its low intervals.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    localparam int VAL_W = 4;
    localparam int SEG_W = 7;

    typedef logic [VAL_W-1:0] val_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Decoder result before pin polarity is applied
    typedef struct packed {
        seg_t lit;      // active-high segment pattern, bit0 = a
        logic dark;     // digit must show nothing
        logic rbo_n;    // ripple-blank output, active low
    } dec_s;

    // Active-high glyph, bit order gfedcba
    function automatic seg_t glyph_of(input val_t v);
        seg_t g;
        case (v)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;  // A
            4'hB: g = 7'h7C;  // b, lower case
            4'hC: g = 7'h39;  // C
            4'hD: g = 7'h5E;  // d, lower case
            4'hE: g = 7'h79;  // E
            default: g = 7'h71;  // F
        endcase
        return g;
    endfunction

endpackage

// File: rtl/seg7_glyph.sv
module seg7_glyph
    import seg7_pkg::*;
(
    input  val_t value,
    output seg_t lit
);
    // Numerals 0-9 (R1) and hex letters 10-15 (R2)
    always_comb begin
        lit = glyph_of(value);
    end
endmodule

// File: rtl/seg7_blank_ctl.sv
module seg7_blank_ctl
    import seg7_pkg::*;
(
    input  val_t value,
    input  logic rb_in_n,
    input  logic blank_n,
    output logic dark,
    output logic rbo_n
);
    logic is_zero;
    logic ripple_hit;

    always_comb begin
        is_zero    = (value == '0);
        // R4/R9: zero suppression applies only when the chain asks for it
        ripple_hit = is_zero && !rb_in_n;
        // R7: forced blank wins over ripple logic and data
        if (!blank_n) begin
            dark  = 1'b1;
            rbo_n = 1'b1;
        end else begin
            dark  = ripple_hit;
            rbo_n = !ripple_hit;  // R6
        end
    end
endmodule

// File: rtl/seg7_drive.sv
module seg7_drive
    import seg7_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  seg_t lit,
    input  logic dark,
    output seg_t pins
);
    seg_t shown;

    always_comb begin
        shown = lit & {SEG_W{~dark}};
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            assign pins = ~shown;   // R3: common-anode drive
        end else begin : g_high
            assign pins = shown;
        end
    endgenerate
endmodule

// File: rtl/sevenseg_rb_dec.sv
module sevenseg_rb_dec
    import seg7_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [3:0] digit_val,
    input  logic       rb_in_n,
    input  logic       blank_n,
    output logic [6:0] seg_n,
    output logic       rb_out_n
);
    seg_t lit_w;
    logic dark_w;
    logic rbo_w;
    dec_s dec_d;

    seg7_glyph u_glyph (
        .value (digit_val),
        .lit   (lit_w)
    );

    seg7_blank_ctl u_blank (
        .value   (digit_val),
        .rb_in_n (rb_in_n),
        .blank_n (blank_n),
        .dark    (dark_w),
        .rbo_n   (rbo_w)
    );

    // Gather decode results; no storage, the chain must ripple in one pass
    always_comb begin
        dec_d.lit   = lit_w;
        dec_d.dark  = dark_w;
        dec_d.rbo_n = rbo_w;
    end

    seg7_drive #(.ACTIVE_LOW(ACTIVE_LOW)) u_drive (
        .lit  (dec_d.lit),
        .dark (dec_d.dark),
        .pins (seg_n)
    );

    assign rb_out_n = dec_d.rbo_n;
endmodule

// File: rtl/seg7_checker.sv
module seg7_checker #(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input logic [3:0] digit_val,
    input logic       rb_in_n,
    input logic       blank_n,
    input logic [6:0] seg_n,
    input logic       rb_out_n
);
    logic [6:0] lit_seen;
    logic       all_dark;

    always_comb begin
        lit_seen = ACTIVE_LOW ? ~seg_n : seg_n;
        all_dark = (lit_seen == 7'h00);

        // R7: forced blank darkens the digit and releases the chain
        a_r7_forced_dark: assert (blank_n || (all_dark && rb_out_n))
            else $error("a_r7_forced_dark violated");
        // R6: ripple output low only for a suppressed zero
        a_r6_rbo_cause: assert (rb_out_n || (blank_n && !rb_in_n && digit_val == 4'h0))
            else $error("a_r6_rbo_cause violated");
        // R4: suppressed zero is dark
        a_r4_zero_dark: assert (!(blank_n && !rb_in_n && digit_val == 4'h0) || all_dark)
            else $error("a_r4_zero_dark violated");
        // R3/R5/R9: any digit not blanked lights at least two segments
        a_r3_visible: assert (!blank_n || (!rb_in_n && digit_val == 4'h0)
                              || $countones(lit_seen) >= 2)
            else $error("a_r3_visible violated");
    end
endmodule

bind sevenseg_rb_dec seg7_checker #(.ACTIVE_LOW(ACTIVE_LOW)) u_chk (
    .digit_val (digit_val),
    .rb_in_n   (rb_in_n),
    .blank_n   (blank_n),
    .seg_n     (seg_n),
    .rb_out_n  (rb_out_n)
);

// File: tb/sevenseg_rb_dec_tb.sv
module sevenseg_rb_dec_tb;

    localparam logic [6:0] DARK = 7'h7F;
    // Expected active-low glyphs from R1/R2
    localparam logic [6:0] GLYPH [16] = '{
        7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
        7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E
    };

    typedef struct packed {
        logic [15:0] value;
        logic [3:0]  dark_mask;  // bit i = digit i expected dark
    } chain_vec_t;

    localparam int NCHAIN = 8;
    localparam chain_vec_t CHAIN_VECS [NCHAIN] = '{
        '{16'h0305, 4'b1000},
        '{16'h0000, 4'b1110},
        '{16'h0007, 4'b1110},
        '{16'h0070, 4'b1100},
        '{16'h1000, 4'b0000},
        '{16'h0A0B, 4'b1000},
        '{16'hF00F, 4'b0000},
        '{16'h00D0, 4'b1100}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;  // 125 MHz

    int checks = 0;
    int errors = 0;

    // Single digit under direct test
    logic [3:0] s_val;
    logic       s_rbi, s_bl;
    logic [6:0] s_seg;
    logic       s_rbo;

    sevenseg_rb_dec u_dut (
        .digit_val (s_val),
        .rb_in_n   (s_rbi),
        .blank_n   (s_bl),
        .seg_n     (s_seg),
        .rb_out_n  (s_rbo)
    );

    // Four-digit chain, index 3 = most significant
    logic [15:0] c_val;
    logic        c_bl;
    logic [6:0]  c_seg [4];
    logic [4:0]  c_rb;

    assign c_rb[4] = 1'b0;  // top digit always may suppress

    for (genvar i = 0; i < 4; i++) begin : g_chain
        logic rbi;
        logic rbo;
        assign rbi = (i == 0) ? 1'b1 : c_rb[i+1];
        assign c_rb[i] = rbo;
        sevenseg_rb_dec u_dig (
            .digit_val (c_val[4*i +: 4]),
            .rb_in_n   (rbi),
            .blank_n   (c_bl),
            .seg_n     (c_seg[i]),
            .rb_out_n  (rbo)
        );
    end

    task automatic check7(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        s_val = 4'h8; s_rbi = 1'b1; s_bl = 1'b0;
        c_val = 16'h1234; c_bl = 1'b0;
        repeat (3) @(posedge clk);
        // Reset state: blank held during reset keeps everything dark (R7)
        settle();
        check7("R7 reset dark", s_seg, DARK);
        check1("R7 reset rbo", s_rbo, 1'b1);
        for (int i = 0; i < 4; i++) check7("R7 reset chain dark", c_seg[i], DARK);
        rst = 1'b0;

        // Sweep of every value, ripple input and forced blank
        for (int v = 0; v < 16; v++) begin
            for (int m = 0; m < 4; m++) begin
                logic [6:0] e_seg;
                logic       e_rbo;
                logic       rbi, bl;
                rbi = m[0];
                bl  = m[1];
                if (!bl) begin
                    e_seg = DARK; e_rbo = 1'b1;                  // R7
                end else if (!rbi && v == 0) begin
                    e_seg = DARK; e_rbo = 1'b0;                  // R4, R6
                end else begin
                    e_seg = GLYPH[v]; e_rbo = 1'b1;              // R1, R2, R5, R9
                end
                @(posedge clk);
                s_val = 4'(v); s_rbi = rbi; s_bl = bl;
                settle();
                if (v >= 10) check7("R2 hex glyph", s_seg, e_seg);
                else if (v == 0 && rbi) check7("R9 zero shown", s_seg, e_seg);
                else if (v == 0) check7("R4 zero suppress", s_seg, e_seg);
                else if (!rbi) check7("R5 nonzero under ripple", s_seg, e_seg);
                else check7("R1 numeral", s_seg, e_seg);
                check1("R6 ripple out", s_rbo, e_rbo);
            end
        end

        // R2: b and d distinct from 8 and 0; R3: dark code is all ones
        check1("R2 b differs from 8", (GLYPH[11] != GLYPH[8]), 1'b1);
        @(posedge clk); s_val = 4'hD; s_rbi = 1'b1; s_bl = 1'b1;
        settle();
        check1("R2 d differs from 0", (s_seg != GLYPH[0]), 1'b1);
        @(posedge clk); s_val = 4'h0; s_rbi = 1'b0;
        settle();
        check7("R3 dark all ones", s_seg, 7'h7F);

        // R8: pulse-width blanking with varied widths, data unchanged
        @(posedge clk); s_val = 4'h6; s_rbi = 1'b1;
        for (int w = 1; w <= 4; w++) begin
            @(posedge clk); s_bl = 1'b0;
            for (int k = 0; k < w; k++) begin
                settle();
                check7("R8 dark while low", s_seg, DARK);
                @(posedge clk);
            end
            s_bl = 1'b1;
            for (int k = 0; k < 5 - w; k++) begin
                settle();
                check7("R8 lit while high", s_seg, GLYPH[6]);
                @(posedge clk);
            end
        end

        // R10: four-digit chain
        c_bl = 1'b1;
        for (int n = 0; n < NCHAIN; n++) begin
            @(posedge clk);
            c_val = CHAIN_VECS[n].value;
            settle();
            for (int i = 0; i < 4; i++) begin
                logic [6:0] e;
                e = CHAIN_VECS[n].dark_mask[i] ? DARK : GLYPH[CHAIN_VECS[n].value[4*i +: 4]];
                check7("R10 chain digit", c_seg[i], e);
            end
        end

        // R7 in a chain: forced blank darkens all digits and releases ripple
        @(posedge clk); c_val = 16'h0305; c_bl = 1'b0;
        settle();
        for (int i = 0; i < 4; i++) check7("R7 chain forced", c_seg[i], DARK);
        check1("R7 chain rbo high", c_rb[3], 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule